// File: doc/BRIEF.md
# Manual Circular Picture Shifter

This block rolls the display coordinates of a 32x32 picture around its edges, horizontally and vertically. Each incoming point is a pair of 5-bit indices. The block adds a per-axis offset to each index, modulo 32, and passes the result on one cycle later. A point that leaves the right or bottom edge comes back in on the opposite side.

Each offset lives in its own 5-bit counter. While an operator holds an axis step-enable, that counter advances by one on each slow tick. The tick comes from a two-stage divide-down cascade run from the fast system clock, so the picture creeps a few steps per second and can be stopped where wanted. Either counter can also be forced to a preset value at any time.

Coordinates flow through a valid/ready pair on each side. The output register holds its point while `out_valid` is high and `out_ready` is low. The input is accepted whenever the output register is empty or is being drained in the same cycle. There is no other storage, so back-pressure reaches the source in the cycle it is applied. The step and preset controls are plain level pins.

Top module: `circ_picture_shifter`

## Requirements
- R1: One clock edge after a coordinate is accepted (`in_valid` and `in_ready` both high), `out_x` equals (`in_x` + horizontal offset) mod 32. The offset used is the value held before that edge.
- R2: In the same way, `out_y` equals (`in_y` + vertical offset) mod 32.
- R3: An offset counter advances by exactly one on a slow tick only when its step-enable is high. At every other edge it keeps its value, and the two axes are independent.
- R4: While an axis preset input is high, that axis offset is loaded at each edge with its 5-bit preset value.
- R5: A preset and a step in the same cycle resolve to the preset value.
- R6: A stepping offset wraps from 31 to 0.
- R7: The slow tick comes once every DIV_LO*DIV_HI clock cycles. The first one is in the cycle after DIV_LO*DIV_HI-1 edges following reset release.
- R8: `in_ready` is high exactly when the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_x` and `out_y` stay unchanged. `out_valid` drops after an edge where `out_ready` is high and nothing is accepted.
- R9: After the asynchronous active-low reset, both offsets are 0, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input coordinate present |
| in_ready | output | 1 | Block can take a coordinate this cycle |
| in_x | input | 5 | Horizontal index in |
| in_y | input | 5 | Vertical index in |
| h_step_en | input | 1 | Hold high to let the horizontal offset step |
| h_preset | input | 1 | Load the horizontal offset from h_preset_val |
| h_preset_val | input | 5 | Horizontal preset value |
| v_step_en | input | 1 | Hold high to let the vertical offset step |
| v_preset | input | 1 | Load the vertical offset from v_preset_val |
| v_preset_val | input | 5 | Vertical preset value |
| out_valid | output | 1 | Shifted coordinate present |
| out_ready | input | 1 | Downstream takes the coordinate |
| out_x | output | 5 | Shifted horizontal index |
| out_y | output | 5 | Shifted vertical index |

## Verification
The bench builds the block with DIV_LO=3 and DIV_HI=2, so a slow tick falls every six clocks instead of millions. Within a few dozen cycles the bench can then step an offset through the 31-to-0 wrap, line a preset up with a tick, and see the tick spacing and first tick position. Back-pressure is applied with irregular `out_ready` patterns while the offsets are stepping, so stalled points must keep their captured value as the offset moves.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int IDX_W = 5;
  localparam int N_AXES = 2;
  typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/step_tick_gen.sv
module step_tick_gen #(
  parameter int DIV_LO = 12500,
  parameter int DIV_HI = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int LO_W = (DIV_LO > 1) ? $clog2(DIV_LO) : 1;
  localparam int HI_W = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;
  localparam logic [LO_W-1:0] LO_LAST = LO_W'(DIV_LO - 1);
  localparam logic [HI_W-1:0] HI_LAST = HI_W'(DIV_HI - 1);

  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;
  logic lo_carry;

  assign lo_carry = (lo_cnt == LO_LAST);
  assign tick = lo_carry && (hi_cnt == HI_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
    end else if (lo_carry) begin
      lo_cnt <= '0;
    end else begin
      lo_cnt <= lo_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (lo_carry) begin
      if (hi_cnt == HI_LAST) hi_cnt <= '0;
      else hi_cnt <= hi_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/offset_counter.sv
module offset_counter
  import shift_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic step_en,
  input  logic preset,
  input  idx_t preset_val,
  output idx_t offset
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset <= '0;
    end else if (preset) begin
      offset <= preset_val;
    end else if (step_en && tick) begin
      offset <= offset + 1'b1;
    end
  end
endmodule

// File: rtl/shift_out_stage.sv
module shift_out_stage
  import shift_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  idx_t in_x,
  input  idx_t in_y,
  input  idx_t off_x,
  input  idx_t off_y,
  output logic out_valid,
  input  logic out_ready,
  output idx_t out_x,
  output idx_t out_y
);
  idx_t sum_x, sum_y;
  logic take;

  assign sum_x = in_x + off_x;
  assign sum_y = in_y + off_y;
  assign in_ready = !out_valid || out_ready;
  assign take = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_x <= '0;
      out_y <= '0;
    end else if (take) begin
      out_x <= sum_x;
      out_y <= sum_y;
    end
  end
endmodule

// File: rtl/circ_picture_shifter.sv
module circ_picture_shifter
  import shift_pkg::*;
#(
  parameter int DIV_LO = 12500,
  parameter int DIV_HI = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [4:0] in_x,
  input  logic [4:0] in_y,
  input  logic       h_step_en,
  input  logic       h_preset,
  input  logic [4:0] h_preset_val,
  input  logic       v_step_en,
  input  logic       v_preset,
  input  logic [4:0] v_preset_val,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [4:0] out_x,
  output logic [4:0] out_y
);
  logic tick;
  logic [N_AXES-1:0] step_a, preset_a;
  idx_t pval_a [N_AXES];
  idx_t off_a  [N_AXES];
  idx_t h_off, v_off;

  assign step_a   = {v_step_en, h_step_en};
  assign preset_a = {v_preset, h_preset};
  assign pval_a[0] = h_preset_val;
  assign pval_a[1] = v_preset_val;
  assign h_off = off_a[0];
  assign v_off = off_a[1];

  step_tick_gen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    offset_counter u_off (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .step_en(step_a[a]), .preset(preset_a[a]),
      .preset_val(pval_a[a]), .offset(off_a[a])
    );
  end

  shift_out_stage u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y),
    .off_x(h_off), .off_y(v_off),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y)
  );
endmodule

// File: rtl/shift_checker.sv
module shift_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [4:0] in_x,
  input logic [4:0] in_y,
  input logic       h_step_en,
  input logic       h_preset,
  input logic [4:0] h_preset_val,
  input logic       out_valid,
  input logic       out_ready,
  input logic [4:0] out_x,
  input logic [4:0] out_y,
  input logic [4:0] h_off,
  input logic [4:0] v_off,
  input logic       tick
);
  logic [4:0] want_x, want_y, h_next;
  assign want_x = in_x + h_off;
  assign want_y = in_y + v_off;
  assign h_next = h_off + 5'd1;

  assert_shift_x_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_x == $past(want_x));
  assert_shift_y_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_y == $past(want_y));
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !h_preset && !h_step_en |=> $stable(h_off));
  assert_step_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !h_preset && h_step_en && tick |=> h_off == $past(h_next));
  assert_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    h_preset |=> h_off == $past(h_preset_val));
  assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y));
  assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);
endmodule

bind circ_picture_shifter shift_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_x(in_x), .in_y(in_y), .h_step_en(h_step_en), .h_preset(h_preset),
  .h_preset_val(h_preset_val), .out_valid(out_valid), .out_ready(out_ready),
  .out_x(out_x), .out_y(out_y), .h_off(h_off), .v_off(v_off), .tick(tick)
);

// File: tb/sim_circ_picture_shifter.sv
`timescale 1ns/1ps
module sim_circ_picture_shifter;
  localparam int LO = 3;
  localparam int HI = 2;
  localparam int PERIOD = LO * HI;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [4:0] in_x = '0, in_y = '0;
  logic h_step_en = 1'b0, h_preset = 1'b0, v_step_en = 1'b0, v_preset = 1'b0;
  logic [4:0] h_preset_val = '0, v_preset_val = '0;
  logic in_ready, out_valid;
  logic [4:0] out_x, out_y;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R9";

  // reference model state
  int m_hoff = 0, m_voff = 0, m_div = 0;
  int m_ox = 0, m_oy = 0;
  bit m_ov = 1'b0;

  always #4 clk = ~clk;

  circ_picture_shifter #(.DIV_LO(LO), .DIV_HI(HI)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .h_step_en(h_step_en), .h_preset(h_preset),
    .h_preset_val(h_preset_val), .v_step_en(v_step_en), .v_preset(v_preset),
    .v_preset_val(v_preset_val), .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hoff = 0; m_voff = 0; m_div = 0; m_ox = 0; m_oy = 0; m_ov = 1'b0;
    end else begin
      bit tk, rdy;
      tk  = (m_div == PERIOD - 1);          // R7 tick position
      rdy = !m_ov || out_ready;              // R8
      if (in_valid && rdy) begin
        m_ox = (in_x + m_hoff) % 32;         // R1
        m_oy = (in_y + m_voff) % 32;         // R2
        m_ov = 1'b1;
      end else if (out_ready) begin
        m_ov = 1'b0;
      end
      if (h_preset) m_hoff = h_preset_val;           // R4 R5
      else if (h_step_en && tk) m_hoff = (m_hoff + 1) % 32; // R3 R6
      if (v_preset) m_voff = v_preset_val;
      else if (v_step_en && tk) m_voff = (m_voff + 1) % 32;
      m_div = (m_div + 1) % PERIOD;
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      check("in_ready", int'(in_ready), int'(!m_ov || out_ready));
      check("out_valid", int'(out_valid), int'(m_ov));
      if (m_ov) begin
        check("out_x", int'(out_x), m_ox);
        check("out_y", int'(out_y), m_oy);
      end
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    cyc(2);
    check("reset out_valid", int'(out_valid), 0);
    check("reset in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    // R1 R2: stream with zero offsets; offsets are 0 after reset (R9)
    cur_req = "R1 R2 R9";
    out_ready = 1'b1; in_valid = 1'b1;
    for (int i = 0; i < 12; i++) begin
      in_x = 5'(i * 3); in_y = 5'(31 - i);
      cyc(1);
    end
    // R4 preset, then shifted stream
    cur_req = "R4 R1 R2";
    h_preset = 1'b1; h_preset_val = 5'd30; v_preset = 1'b1; v_preset_val = 5'd7;
    cyc(1);
    h_preset = 1'b0; v_preset = 1'b0;
    for (int i = 0; i < 10; i++) begin
      in_x = 5'(i * 5 + 1); in_y = 5'(i * 7 + 20);
      cyc(1);
    end
    // R3 R6 R7: horizontal stepping across the wrap, vertical held
    cur_req = "R3 R6 R7";
    in_x = 5'd0; in_y = 5'd0;
    h_step_en = 1'b1;
    cyc(PERIOD * 5 + 2);
    h_step_en = 1'b0;
    cyc(PERIOD * 2);
    // R3 vertical alone
    cur_req = "R3 R7";
    v_step_en = 1'b1;
    cyc(PERIOD * 3);
    v_step_en = 1'b0;
    // R5 preset held across ticks with stepping enabled
    cur_req = "R5";
    h_step_en = 1'b1; h_preset = 1'b1; h_preset_val = 5'd31;
    v_step_en = 1'b1; v_preset = 1'b1; v_preset_val = 5'd31;
    cyc(PERIOD * 2 + 1);
    h_preset = 1'b0; v_preset = 1'b0;
    cyc(PERIOD + 1);
    // R8 back-pressure with offsets moving
    cur_req = "R8 R1";
    for (int i = 0; i < 40; i++) begin
      out_ready = ((i % 5) == 1) || ((i % 7) == 3);
      in_valid = (i % 3) != 2;
      in_x = 5'(i); in_y = 5'(i * 11);
      cyc(1);
    end
    out_ready = 1'b1; in_valid = 1'b0;
    h_step_en = 1'b0; v_step_en = 1'b0;
    cyc(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule